// File: doc/BRIEF.md
# Interrupt Cause Status Register

This block gathers interrupt causes from a contactless front end into one 8-bit status word and drives a single interrupt request line towards the host. Transmit, receive, FIFO-threshold, error and timeout events arrive as one-cycle strobes. Each strobe sets its own flag, and a flag stays set until the register is cleared. Most causes raise the request line at once. The transmit and receive flags are different: each flag marks an activity as soon as it begins, but the request line rises only when that activity finishes.

The host clears the whole word, and the request line with it, when a read phase ends or when it writes the protocol control register. Pulling the enable input low, or asserting the active-low power-on reset, also forces the word and the line to zero. A small counter watches collision samples inside each 106 kbps bit period and produces the collision cause once the count goes past a threshold of 6 or 7.

All control and status pins are plain levels or strobes. No handshake is needed, because every strobe is taken in the cycle it is high and every output is a register.

Top module: `irq_cause_reg`

## Requirements
- R1: Each cause has a fixed bit position in `status`: 7 transmit, 6 receive start, 5 FIFO level, 4 CRC error, 3 parity error, 2 framing/EOF error, 1 collision, 0 no-response timeout. A strobe on `fifo_lvl`, `parity_err`, `frame_err` or `noresp_to` sets its bit, and `irq` is high after the same clock edge.
- R2: `tx_start` sets bit 7 without raising `irq`. `irq` rises on the edge that samples `tx_end`.
- R3: `rx_sof` sets bit 6 without raising `irq`. `irq` rises on the edge that samples `rx_end`, and this includes the case where `rx_sof` and `rx_end` come in the same cycle.
- R4: `crc_err` sets bit 4 only while `crc_chk_off` is 0. While `crc_chk_off` is 1 the strobe is ignored.
- R5: Collision samples are counted within one bit period, and `bit_tick` starts a new period. When `coll_thr_sel` is 0, the 7th sample of a period sets bit 1 and raises `irq`. When `coll_thr_sel` is 1, the 8th sample does this. Samples at or below the threshold have no effect.
- R6: A pulse on `rd_done` clears `status` and `irq` to zero on the next edge.
- R7: A pulse on `ctrl_wr` clears `status` and `irq` to zero on the next edge.
- R8: `por_n` low clears everything asynchronously. While `enable` is low, `status` and `irq` are held at zero and all causes are ignored.
- R9: A cause that arrives in the same cycle as `rd_done` or `ctrl_wr` survives the clear. Its bit is set and, following R1 to R3, `irq` reflects it.
- R10: A set flag stays set while other causes arrive, until one of the clears in R6 to R8 takes effect.
- R11: An end strobe (`tx_end` or `rx_end`) does not raise `irq` when the matching start flag is neither set nor being set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| enable | input | 1 | Chip enable; low holds everything cleared |
| tx_start | input | 1 | Transmission began (strobe) |
| tx_end | input | 1 | Transmission finished (strobe) |
| rx_sof | input | 1 | Receive start-of-frame seen (strobe) |
| rx_end | input | 1 | Reception finished (strobe) |
| fifo_lvl | input | 1 | FIFO threshold crossed (strobe) |
| crc_err | input | 1 | Receive CRC error (strobe) |
| parity_err | input | 1 | Parity error (strobe) |
| frame_err | input | 1 | Byte framing or EOF error (strobe) |
| coll_smp | input | 1 | One collision sample (strobe) |
| bit_tick | input | 1 | Start of a new 106 kbps bit period |
| coll_thr_sel | input | 1 | Collision threshold: 0 = more than 6, 1 = more than 7 |
| noresp_to | input | 1 | No-response timeout (strobe) |
| crc_chk_off | input | 1 | Receive CRC checking disabled |
| ctrl_wr | input | 1 | Protocol control register written (strobe) |
| rd_done | input | 1 | Host read phase finished (strobe) |
| status | output | 8 | Interrupt cause flags |
| irq | output | 1 | Interrupt request to host |

## Verification
The race that matters most is a clear landing in the same cycle as a new cause. The bench drives `rd_done` together with `parity_err`, and separately `ctrl_wr` together with `tx_start`, with and without `tx_end`. It then judges the word and the request line on the next edge, where the new bit must be set and the line must follow the deferred or immediate rule for that cause. A second coincidence is a start and an end strobe in the same cycle, which has to raise the line even though the start flag was not yet registered.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W   = 8;
  localparam int B_TX     = 7;
  localparam int B_RXS    = 6;
  localparam int B_FIFO   = 5;
  localparam int B_CRC    = 4;
  localparam int B_PAR    = 3;
  localparam int B_FRAME  = 2;
  localparam int B_COLL   = 1;
  localparam int B_NORESP = 0;
  // bits that raise the request as soon as they set
  localparam logic [STAT_W-1:0] IMM_MASK = 8'h3F;
endpackage

// File: rtl/irq_coll_detect.sv
module irq_coll_detect #(
  parameter int CNT_W  = 4,
  parameter int THR_LO = 6,
  parameter int THR_HI = 7
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic smp,
  input  logic tick,
  input  logic thr_sel,
  output logic hit
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TLO  = CNT_W'(THR_LO);
  localparam logic [CNT_W-1:0] THI  = CNT_W'(THR_HI);

  logic [CNT_W-1:0] cnt_q, base, thr;

  always_comb begin
    base = tick ? '0 : cnt_q;
    thr  = thr_sel ? THI : TLO;
    hit  = smp && (base >= thr);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (smp && base != CMAX)   cnt_q <= base + 1'b1;
    else                            cnt_q <= base;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         clr_hard,
  input  logic         clr_soft,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        q[i] <= 1'b0;
      else if (clr_hard) q[i] <= 1'b0;
      else if (clr_soft) q[i] <= set_vec[i];
      else               q[i] <= q[i] | set_vec[i];
    end
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              clr_hard,
  input  logic              clr_soft,
  input  logic [STAT_W-1:0] flags_q,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              tx_end,
  input  logic              rx_end,
  output logic              irq_q
);
  logic keep_tx, keep_rx, fire;

  always_comb begin
    keep_tx = set_vec[B_TX]  | (flags_q[B_TX]  & ~clr_soft);
    keep_rx = set_vec[B_RXS] | (flags_q[B_RXS] & ~clr_soft);
    fire    = (|(set_vec & IMM_MASK)) | (tx_end & keep_tx) | (rx_end & keep_rx);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        irq_q <= 1'b0;
    else if (clr_hard) irq_q <= 1'b0;
    else if (clr_soft) irq_q <= fire;
    else               irq_q <= irq_q | fire;
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_pkg::*;
#(
  parameter int COLL_CNT_W = 4,
  parameter int COLL_LO    = 6,
  parameter int COLL_HI    = 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              enable,
  input  logic              tx_start,
  input  logic              tx_end,
  input  logic              rx_sof,
  input  logic              rx_end,
  input  logic              fifo_lvl,
  input  logic              crc_err,
  input  logic              parity_err,
  input  logic              frame_err,
  input  logic              coll_smp,
  input  logic              bit_tick,
  input  logic              coll_thr_sel,
  input  logic              noresp_to,
  input  logic              crc_chk_off,
  input  logic              ctrl_wr,
  input  logic              rd_done,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic              clr_hard, clr_soft, coll_hit;
  logic [STAT_W-1:0] set_vec;

  always_comb begin
    clr_hard = ~enable;
    clr_soft = ctrl_wr | rd_done;
    set_vec           = '0;
    set_vec[B_TX]     = tx_start;
    set_vec[B_RXS]    = rx_sof;
    set_vec[B_FIFO]   = fifo_lvl;
    set_vec[B_CRC]    = crc_err & ~crc_chk_off;
    set_vec[B_PAR]    = parity_err;
    set_vec[B_FRAME]  = frame_err;
    set_vec[B_COLL]   = coll_hit;
    set_vec[B_NORESP] = noresp_to;
  end

  irq_coll_detect #(
    .CNT_W (COLL_CNT_W),
    .THR_LO(COLL_LO),
    .THR_HI(COLL_HI)
  ) u_coll (
    .clk    (clk),
    .por_n  (por_n),
    .clr    (clr_hard),
    .smp    (coll_smp),
    .tick   (bit_tick),
    .thr_sel(coll_thr_sel),
    .hit    (coll_hit)
  );

  irq_flag_bank #(.W(STAT_W)) u_flags (
    .clk     (clk),
    .por_n   (por_n),
    .clr_hard(clr_hard),
    .clr_soft(clr_soft),
    .set_vec (set_vec),
    .q       (status)
  );

  irq_req_gen u_req (
    .clk     (clk),
    .por_n   (por_n),
    .clr_hard(clr_hard),
    .clr_soft(clr_soft),
    .flags_q (status),
    .set_vec (set_vec),
    .tx_end  (tx_end),
    .rx_end  (rx_end),
    .irq_q   (irq)
  );
endmodule

// File: rtl/irq_cause_reg_chk.sv
module irq_cause_reg_chk (
  input logic       clk,
  input logic       por_n,
  input logic       enable,
  input logic       tx_start,
  input logic       tx_end,
  input logic       rx_sof,
  input logic       rx_end,
  input logic       fifo_lvl,
  input logic       crc_err,
  input logic       parity_err,
  input logic       frame_err,
  input logic       coll_smp,
  input logic       noresp_to,
  input logic       crc_chk_off,
  input logic       ctrl_wr,
  input logic       rd_done,
  input logic [7:0] status,
  input logic       irq
);
  logic quiet;
  assign quiet = !tx_start && !tx_end && !rx_sof && !rx_end && !fifo_lvl && !crc_err &&
                 !parity_err && !frame_err && !coll_smp && !noresp_to;

  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !enable |=> (status == 8'h00) && !irq); // R8

  AST_TX_DEFERRED: assert property (@(posedge clk) disable iff (!por_n)
    (enable && tx_start && !irq && quiet == 1'b0 && !tx_end && !rx_end && !fifo_lvl &&
     !crc_err && !parity_err && !frame_err && !coll_smp && !noresp_to) |=> !irq); // R2

  AST_CRC_MASKED: assert property (@(posedge clk) disable iff (!por_n)
    (crc_chk_off && !status[4]) |=> !status[4]); // R4

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (rd_done && quiet) |=> (status == 8'h00) && !irq); // R6

  AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_wr && quiet) |=> (status == 8'h00) && !irq); // R7

  AST_CAUSE_WINS: assert property (@(posedge clk) disable iff (!por_n)
    (enable && rd_done && parity_err) |=> status[3] && irq); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (enable && !rd_done && !ctrl_wr) |=> ((status & $past(status)) == $past(status))); // R10

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> (status != 8'h00)); // R11
endmodule

bind irq_cause_reg irq_cause_reg_chk u_chk (.*);

// File: tb/irq_cause_reg_tb.sv
module irq_cause_reg_tb;
  localparam int I_TXS = 0, I_TXE = 1, I_RXS = 2, I_RXE = 3, I_FIFO = 4, I_CRC = 5,
                 I_PAR = 6, I_FRM = 7, I_CSMP = 8, I_TICK = 9, I_NORESP = 10,
                 I_RD = 11, I_WR = 12, I_DIS = 13, I_CRCOFF = 14, I_THR = 15;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    string      tag;
  } exp_t;

  logic clk = 1'b0, por_n = 1'b0;
  logic [15:0] drv = '0;
  logic [7:0]  status;
  logic        irq;
  int n_chk = 0, n_fail = 0, cyc = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  irq_cause_reg u_dut (
    .clk(clk), .por_n(por_n), .enable(!drv[I_DIS]),
    .tx_start(drv[I_TXS]), .tx_end(drv[I_TXE]), .rx_sof(drv[I_RXS]), .rx_end(drv[I_RXE]),
    .fifo_lvl(drv[I_FIFO]), .crc_err(drv[I_CRC]), .parity_err(drv[I_PAR]),
    .frame_err(drv[I_FRM]), .coll_smp(drv[I_CSMP]), .bit_tick(drv[I_TICK]),
    .coll_thr_sel(drv[I_THR]), .noresp_to(drv[I_NORESP]), .crc_chk_off(drv[I_CRCOFF]),
    .ctrl_wr(drv[I_WR]), .rd_done(drv[I_RD]), .status(status), .irq(irq)
  );

  task automatic check(input logic [7:0] es, input logic ei, input string tag);
    n_chk++;
    if (status !== es || irq !== ei) begin
      n_fail++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", tag, status, irq, es, ei);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected post-edge result
  task automatic step(input logic [15:0] s, input logic [7:0] es, input logic ei, input string tag);
    exp_t e;
    @(negedge clk);
    drv = s;
    e.st = es; e.irq = ei; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.st, e.irq, e.tag);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected completion", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(8'h00, 1'b0, "R8 reset state");
    por_n = 1'b1;
    // R2 transmit deferred request, R6 read clear
    step(16'(1 << I_TXS), 8'h80, 0, "R2 tx start flag");
    step(16'h0,           8'h80, 0, "R2 tx no early irq");
    step(16'(1 << I_TXE), 8'h80, 1, "R2 tx end irq");
    step(16'(1 << I_RD),  8'h00, 0, "R6 read clear");
    // R3 receive, R7 control write clear
    step(16'(1 << I_RXS), 8'h40, 0, "R3 rx sof flag");
    step(16'(1 << I_RXE), 8'h40, 1, "R3 rx end irq");
    step(16'(1 << I_WR),  8'h00, 0, "R7 write clear");
    // R11 orphan end strobes
    step(16'(1 << I_TXE), 8'h00, 0, "R11 tx end alone");
    step(16'(1 << I_RXE), 8'h00, 0, "R11 rx end alone");
    // R1 immediate causes, R10 sticky
    step(16'(1 << I_FIFO),   8'h20, 1, "R1 fifo");
    step(16'(1 << I_PAR),    8'h28, 1, "R1 parity R10");
    step(16'(1 << I_FRM),    8'h2C, 1, "R1 frame R10");
    step(16'(1 << I_NORESP), 8'h2D, 1, "R1 noresp R10");
    step(16'h0,              8'h2D, 1, "R10 hold");
    step(16'(1 << I_RD),     8'h00, 0, "R6 read clear 2");
    // R4 CRC gate
    step(16'((1 << I_CRC) | (1 << I_CRCOFF)), 8'h00, 0, "R4 crc ignored");
    step(16'(1 << I_CRC),    8'h10, 1, "R4 crc sets");
    step(16'(1 << I_RD),     8'h00, 0, "R6 read clear 3");
    // R5 collision threshold 6
    step(16'(1 << I_TICK), 8'h00, 0, "R5 period start");
    for (int i = 0; i < 6; i++) step(16'(1 << I_CSMP), 8'h00, 0, "R5 below thr6");
    step(16'(1 << I_CSMP), 8'h02, 1, "R5 7th sample");
    step(16'(1 << I_RD),   8'h00, 0, "R6 read clear 4");
    // R5 collision threshold 7
    step(16'((1 << I_TICK) | (1 << I_THR)), 8'h00, 0, "R5 period start hi");
    for (int i = 0; i < 7; i++) step(16'((1 << I_CSMP) | (1 << I_THR)), 8'h00, 0, "R5 below thr7");
    step(16'((1 << I_CSMP) | (1 << I_THR)), 8'h02, 1, "R5 8th sample");
    step(16'(1 << I_RD),   8'h00, 0, "R6 read clear 5");
    // R5 restart by bit_tick
    step(16'((1 << I_TICK) | (1 << I_CSMP)), 8'h00, 0, "R5 tick plus sample");
    for (int i = 0; i < 5; i++) step(16'(1 << I_CSMP), 8'h00, 0, "R5 count to six");
    step(16'((1 << I_TICK) | (1 << I_CSMP)), 8'h00, 0, "R5 tick restarts");
    step(16'(1 << I_CSMP), 8'h00, 0, "R5 after restart");
    // R9 cause wins over clear
    step(16'(1 << I_FIFO), 8'h20, 1, "R9 preload");
    step(16'((1 << I_RD) | (1 << I_PAR)), 8'h08, 1, "R9 read with parity");
    step(16'((1 << I_WR) | (1 << I_TXS)), 8'h80, 0, "R9 write with tx start");
    step(16'((1 << I_WR) | (1 << I_TXS) | (1 << I_TXE)), 8'h80, 1, "R9 write with tx start end");
    step(16'(1 << I_WR), 8'h00, 0, "R7 write clear 2");
    // R3 start and end together
    step(16'((1 << I_RXS) | (1 << I_RXE)), 8'h40, 1, "R3 sof and end same cycle");
    // R8 enable low
    step(16'(1 << I_DIS), 8'h00, 0, "R8 disable clears");
    step(16'((1 << I_DIS) | (1 << I_FIFO) | (1 << I_TXS)), 8'h00, 0, "R8 causes ignored");
    step(16'h0, 8'h00, 0, "R8 re-enabled idle");
    step(16'h0, 8'h00, 0, "R8 drain");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule